// File: doc/BRIEF.md
# Write-Through Invalidating Snooping Cache Controller

This block is the private cache controller that sits between one processor and a shared, atomic system bus in a small shared-memory multiprocessor. It holds a direct-mapped array of lines. Each line carries a single valid flag, so its state is either present or not present. Reads that find their line present are answered locally. A read that misses fetches the whole line over the bus and installs it. Every store is sent straight through to memory over the bus. A store never brings a missing line into the cache. When a store finds its line present, the local copy is patched.

The controller also watches every transaction on the bus through a snoop port. When another master writes to a line that is held here, that line is dropped. The next local read of that line therefore misses and picks up the newer value. Bus reads from other masters, and transactions that carry this controller's own master number, leave the array untouched.

A bus transaction moves through three phases in order. First the controller raises a request and waits for a grant. Then it drives the command and address for one cycle. Then it waits in the data phase until the bus signals completion. The processor sees a stall from the first cycle of any request that needs the bus until the cycle in which the data phase ends.

Top module: `wt_snoop_cache`

## Requirements
- R1: After reset every line is not present, and `cpu_stall_o`, `cpu_rvalid_o`, `bus_req_o` and `bus_cmd_vld_o` are all 0.
- R2: A read whose line is not present issues exactly one bus read (`bus_cmd_o` = 0). Its `bus_addr_o` is the request address with the low log2(LINE_WORDS) bits cleared. The addressed word of `bus_rdata_i` (word w at bits w*WORD_W upward) is returned with `cpu_rvalid_o` in the cycle `bus_done_i` is high, and the line becomes present.
- R3: A read whose line is present returns the stored word with `cpu_rvalid_o` in the same cycle. It does not stall and starts no bus transaction.
- R4: Every write issues exactly one bus write (`bus_cmd_o` = 1) carrying the unmodified word address and the write data. A write whose line is present updates that stored word, and the line stays present.
- R5: A write whose line is not present leaves the line not present, so the next read of that line misses.
- R6: A snooped write (`snp_cmd_i` = 1) from another master whose address matches a present line in both index and tag makes that line not present. A snooped write that matches the index but not the tag leaves the line present.
- R7: A snooped read (`snp_cmd_i` = 0) from another master, and any snooped transaction whose `snp_mid_i` equals MASTER_ID, leave the line state unchanged.
- R8: `bus_req_o` stays high until `bus_gnt_i`. `bus_cmd_vld_o` is high for exactly the one cycle after the grant. The data phase lasts until `bus_done_i`. A request that waits G cycles for its grant and whose memory adds L cycles therefore stalls the processor for G+L+3 cycles.
- R9: `cpu_stall_o` is high from the cycle a request needs the bus until the cycle before the data phase ends, and is low in that final cycle. `cpu_rvalid_o` is never high while `cpu_stall_o` is high.
- R10: If another master's write to the same line is snooped in the cycle a pending read miss receives its grant, the invalidation is applied first. The miss then fills with the newer value, and the line is left present.
- R11: Two addresses with the same index but different tags share one line: reading one replaces the other, and reading the other again misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cpu_req_i | input | 1 | Processor request, held while stalled |
| cpu_we_i | input | 1 | 1 = write, 0 = read |
| cpu_addr_i | input | ADDR_W | Word address |
| cpu_wdata_i | input | WORD_W | Write data |
| cpu_stall_o | output | 1 | Processor must hold its request |
| cpu_rvalid_o | output | 1 | Read data valid |
| cpu_rdata_o | output | WORD_W | Read data |
| bus_req_o | output | 1 | Bus arbitration request |
| bus_gnt_i | input | 1 | Bus grant |
| bus_cmd_vld_o | output | 1 | Command/address phase valid |
| bus_cmd_o | output | 1 | 0 = line read, 1 = word write |
| bus_addr_o | output | ADDR_W | Bus address |
| bus_wdata_o | output | WORD_W | Bus write data |
| bus_done_i | input | 1 | Last cycle of the data phase |
| bus_rdata_i | input | WORD_W*LINE_WORDS | Refill line |
| snp_vld_i | input | 1 | Snooped transaction valid |
| snp_cmd_i | input | 1 | Snooped command, 0 = read, 1 = write |
| snp_addr_i | input | ADDR_W | Snooped address |
| snp_mid_i | input | MID_W | Master number of the snooped transaction |

## Verification
A read hit is due in the same cycle as its request. A request that needs the bus completes in the (G+L+4)th cycle, counted from the request cycle, where G is the grant delay and L is the extra memory latency that the bench bus model applies. The bench drives stimulus and samples outputs at mid-cycle, one time unit after the falling edge. It counts the stalled samples of each request and compares that count with G+L+3. Read data goes into a scoreboard queue and is popped whenever `cpu_rvalid_o` is sampled high. A snoop is injected one cycle before the next access so that its effect has been registered when the access is sampled. Snoop and fill effects are judged by the number of bus reads the bus model records.

// File: rtl/wtc_pkg.sv
package wtc_pkg;
  typedef enum logic [1:0] {
    BS_IDLE = 2'd0,
    BS_ARB  = 2'd1,
    BS_CMD  = 2'd2,
    BS_DATA = 2'd3
  } bus_st_e;

  localparam logic CMD_RD = 1'b0;
  localparam logic CMD_WR = 1'b1;
endpackage

// File: rtl/wtc_tag_array.sv
module wtc_tag_array #(
  parameter int NUM_LINES = 8,
  parameter int IDX_W     = 3,
  parameter int TAG_W     = 11
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IDX_W-1:0] a_idx_i,
  input  logic [TAG_W-1:0] a_tag_i,
  output logic             a_hit_o,
  input  logic [IDX_W-1:0] b_idx_i,
  input  logic [TAG_W-1:0] b_tag_i,
  output logic             b_hit_o,
  input  logic             inv_i,
  input  logic [IDX_W-1:0] inv_idx_i,
  input  logic [TAG_W-1:0] inv_tag_i,
  input  logic             fill_i,
  input  logic [IDX_W-1:0] fill_idx_i,
  input  logic [TAG_W-1:0] fill_tag_i
);
  logic [NUM_LINES-1:0] valid_vec;
  logic [TAG_W-1:0]     tag_arr [NUM_LINES];

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
    logic             v_q;
    logic [TAG_W-1:0] t_q;
    logic             sel_fill, sel_inv;

    assign sel_fill = fill_i && (fill_idx_i == IDX_W'(g));
    assign sel_inv  = inv_i && (inv_idx_i == IDX_W'(g)) && (t_q == inv_tag_i);

    // fill wins: a snoop seen in the same cycle is ordered before the refill
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        v_q <= 1'b0;
        t_q <= '0;
      end else if (sel_fill) begin
        v_q <= 1'b1;
        t_q <= fill_tag_i;
      end else if (sel_inv) begin
        v_q <= 1'b0;
      end
    end

    assign valid_vec[g] = v_q;
    assign tag_arr[g]   = t_q;
  end

  assign a_hit_o = valid_vec[a_idx_i] && (tag_arr[a_idx_i] == a_tag_i);
  assign b_hit_o = valid_vec[b_idx_i] && (tag_arr[b_idx_i] == b_tag_i);
endmodule

// File: rtl/wtc_data_array.sv
module wtc_data_array #(
  parameter int NUM_LINES  = 8,
  parameter int LINE_WORDS = 4,
  parameter int WORD_W     = 32,
  parameter int IDX_W      = 3,
  parameter int OFF_W      = 2,
  localparam int LINE_W    = WORD_W * LINE_WORDS,
  localparam int NWORDS    = NUM_LINES * LINE_WORDS
) (
  input  logic              clk_i,
  input  logic [IDX_W-1:0]  rd_idx_i,
  input  logic [OFF_W-1:0]  rd_off_i,
  output logic [WORD_W-1:0] rd_word_o,
  input  logic              fill_i,
  input  logic [IDX_W-1:0]  fill_idx_i,
  input  logic [LINE_W-1:0] fill_line_i,
  input  logic              wr_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [OFF_W-1:0]  wr_off_i,
  input  logic [WORD_W-1:0] wr_word_i
);
  logic [WORD_W-1:0] words [NWORDS];

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
    for (genvar w = 0; w < LINE_WORDS; w++) begin : g_word
      logic [WORD_W-1:0] d_q;
      always_ff @(posedge clk_i) begin
        if (fill_i && fill_idx_i == IDX_W'(g))
          d_q <= fill_line_i[w*WORD_W +: WORD_W];
        else if (wr_i && wr_idx_i == IDX_W'(g) && wr_off_i == OFF_W'(w))
          d_q <= wr_word_i;
      end
      assign words[g*LINE_WORDS + w] = d_q;
    end
  end

  assign rd_word_o = words[{rd_idx_i, rd_off_i}];
endmodule

// File: rtl/wtc_bus_fsm.sv
module wtc_bus_fsm
  import wtc_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int WORD_W     = 32,
  parameter int LINE_WORDS = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [WORD_W-1:0] wdata_i,
  input  logic              gnt_i,
  input  logic              done_i,
  output logic              req_o,
  output logic              cmd_vld_o,
  output logic              cmd_o,
  output logic [ADDR_W-1:0] baddr_o,
  output logic [WORD_W-1:0] bwdata_o,
  output logic              busy_o,
  output logic              fin_o,
  output logic              x_we_o,
  output logic [ADDR_W-1:0] x_addr_o
);
  localparam logic [ADDR_W-1:0] LINE_MASK = ~ADDR_W'(LINE_WORDS - 1);

  bus_st_e           st_q;
  logic              we_q;
  logic [ADDR_W-1:0] addr_q;
  logic [WORD_W-1:0] wdata_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= BS_IDLE;
      we_q    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
    end else begin
      unique case (st_q)
        BS_IDLE: if (start_i) begin
          st_q    <= BS_ARB;
          we_q    <= we_i;
          addr_q  <= addr_i;
          wdata_q <= wdata_i;
        end
        BS_ARB:  if (gnt_i) st_q <= BS_CMD;
        BS_CMD:  st_q <= BS_DATA;
        BS_DATA: if (done_i) st_q <= BS_IDLE;
        default: st_q <= BS_IDLE;
      endcase
    end
  end

  assign req_o     = (st_q == BS_ARB);
  assign cmd_vld_o = (st_q == BS_CMD);
  assign cmd_o     = we_q ? CMD_WR : CMD_RD;
  assign baddr_o   = we_q ? addr_q : (addr_q & LINE_MASK);
  assign bwdata_o  = wdata_q;
  assign busy_o    = (st_q != BS_IDLE);
  assign fin_o     = (st_q == BS_DATA) && done_i;
  assign x_we_o    = we_q;
  assign x_addr_o  = addr_q;
endmodule

// File: rtl/wt_snoop_cache.sv
module wt_snoop_cache
  import wtc_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int WORD_W     = 32,
  parameter int LINE_WORDS = 4,
  parameter int NUM_LINES  = 8,
  parameter int MID_W      = 2,
  parameter int MASTER_ID  = 0,
  localparam int OFF_W     = $clog2(LINE_WORDS),
  localparam int IDX_W     = $clog2(NUM_LINES),
  localparam int TAG_W     = ADDR_W - IDX_W - OFF_W,
  localparam int LINE_W    = WORD_W * LINE_WORDS
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cpu_req_i,
  input  logic              cpu_we_i,
  input  logic [ADDR_W-1:0] cpu_addr_i,
  input  logic [WORD_W-1:0] cpu_wdata_i,
  output logic              cpu_stall_o,
  output logic              cpu_rvalid_o,
  output logic [WORD_W-1:0] cpu_rdata_o,
  output logic              bus_req_o,
  input  logic              bus_gnt_i,
  output logic              bus_cmd_vld_o,
  output logic              bus_cmd_o,
  output logic [ADDR_W-1:0] bus_addr_o,
  output logic [WORD_W-1:0] bus_wdata_o,
  input  logic              bus_done_i,
  input  logic [LINE_W-1:0] bus_rdata_i,
  input  logic              snp_vld_i,
  input  logic              snp_cmd_i,
  input  logic [ADDR_W-1:0] snp_addr_i,
  input  logic [MID_W-1:0]  snp_mid_i
);
  // address fields
  logic [IDX_W-1:0]  c_idx, x_idx, s_idx;
  logic [TAG_W-1:0]  c_tag, x_tag, s_tag;
  logic [OFF_W-1:0]  c_off, x_off;
  logic [ADDR_W-1:0] x_addr;

  assign c_idx = cpu_addr_i[OFF_W +: IDX_W];
  assign c_tag = cpu_addr_i[ADDR_W-1 -: TAG_W];
  assign c_off = cpu_addr_i[OFF_W-1:0];
  assign x_idx = x_addr[OFF_W +: IDX_W];
  assign x_tag = x_addr[ADDR_W-1 -: TAG_W];
  assign x_off = x_addr[OFF_W-1:0];
  assign s_idx = snp_addr_i[OFF_W +: IDX_W];
  assign s_tag = snp_addr_i[ADDR_W-1 -: TAG_W];

  logic c_hit, x_hit;
  logic bus_busy, fin, x_we;
  logic need_bus, start;
  logic snp_inv, do_fill, do_wr;
  logic [WORD_W-1:0] arr_word;
  logic [WORD_W-1:0] line_words [LINE_WORDS];

  assign need_bus = cpu_req_i && (cpu_we_i || !c_hit);
  assign start    = !bus_busy && need_bus;
  assign snp_inv  = snp_vld_i && (snp_cmd_i == CMD_WR) && (snp_mid_i != MID_W'(MASTER_ID));
  assign do_fill  = fin && !x_we;
  assign do_wr    = fin && x_we && x_hit;

  wtc_bus_fsm #(
    .ADDR_W    (ADDR_W),
    .WORD_W    (WORD_W),
    .LINE_WORDS(LINE_WORDS)
  ) u_fsm (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start),
    .we_i     (cpu_we_i),
    .addr_i   (cpu_addr_i),
    .wdata_i  (cpu_wdata_i),
    .gnt_i    (bus_gnt_i),
    .done_i   (bus_done_i),
    .req_o    (bus_req_o),
    .cmd_vld_o(bus_cmd_vld_o),
    .cmd_o    (bus_cmd_o),
    .baddr_o  (bus_addr_o),
    .bwdata_o (bus_wdata_o),
    .busy_o   (bus_busy),
    .fin_o    (fin),
    .x_we_o   (x_we),
    .x_addr_o (x_addr)
  );

  wtc_tag_array #(
    .NUM_LINES(NUM_LINES),
    .IDX_W    (IDX_W),
    .TAG_W    (TAG_W)
  ) u_tags (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .a_idx_i   (c_idx),
    .a_tag_i   (c_tag),
    .a_hit_o   (c_hit),
    .b_idx_i   (x_idx),
    .b_tag_i   (x_tag),
    .b_hit_o   (x_hit),
    .inv_i     (snp_inv),
    .inv_idx_i (s_idx),
    .inv_tag_i (s_tag),
    .fill_i    (do_fill),
    .fill_idx_i(x_idx),
    .fill_tag_i(x_tag)
  );

  wtc_data_array #(
    .NUM_LINES (NUM_LINES),
    .LINE_WORDS(LINE_WORDS),
    .WORD_W    (WORD_W),
    .IDX_W     (IDX_W),
    .OFF_W     (OFF_W)
  ) u_data (
    .clk_i      (clk_i),
    .rd_idx_i   (c_idx),
    .rd_off_i   (c_off),
    .rd_word_o  (arr_word),
    .fill_i     (do_fill),
    .fill_idx_i (x_idx),
    .fill_line_i(bus_rdata_i),
    .wr_i       (do_wr),
    .wr_idx_i   (x_idx),
    .wr_off_i   (x_off),
    .wr_word_i  (bus_wdata_o)
  );

  for (genvar w = 0; w < LINE_WORDS; w++) begin : g_slice
    assign line_words[w] = bus_rdata_i[w*WORD_W +: WORD_W];
  end

  assign cpu_stall_o  = start || (bus_busy && !fin);
  assign cpu_rvalid_o = (!bus_busy && cpu_req_i && !cpu_we_i && c_hit) || do_fill;
  assign cpu_rdata_o  = do_fill ? line_words[x_off] : arr_word;
endmodule

// File: rtl/wtc_checker.sv
module wtc_checker (
  input logic clk_i,
  input logic rst_ni,
  input logic cpu_req_i,
  input logic cpu_we_i,
  input logic cpu_stall_o,
  input logic cpu_rvalid_o,
  input logic bus_req_o,
  input logic bus_gnt_i,
  input logic bus_cmd_vld_o,
  input logic bus_done_i,
  input logic bus_busy
);
  AST_REQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_o && !bus_gnt_i |=> bus_req_o); // R8
  AST_CMD_AFTER_GNT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_o && bus_gnt_i |=> bus_cmd_vld_o && !bus_req_o); // R8
  AST_CMD_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_cmd_vld_o |=> !bus_cmd_vld_o); // R8
  AST_RVALID_UNSTALLED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_rvalid_o |-> !cpu_stall_o); // R9
  AST_HIT_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_rvalid_o && !bus_done_i |=> !bus_req_o); // R3
  AST_WRITE_OUT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_req_i && cpu_we_i && !bus_busy |=> bus_req_o); // R4
  AST_RELEASE_ENDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_busy && !cpu_stall_o |=> !bus_busy); // R9
endmodule

bind wt_snoop_cache wtc_checker u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .cpu_req_i    (cpu_req_i),
  .cpu_we_i     (cpu_we_i),
  .cpu_stall_o  (cpu_stall_o),
  .cpu_rvalid_o (cpu_rvalid_o),
  .bus_req_o    (bus_req_o),
  .bus_gnt_i    (bus_gnt_i),
  .bus_cmd_vld_o(bus_cmd_vld_o),
  .bus_done_i   (bus_done_i),
  .bus_busy     (bus_busy)
);

// File: tb/tb_wt_snoop_cache.sv
module tb_wt_snoop_cache;
  localparam int CLK_P  = 10;
  localparam int AW     = 16;
  localparam int WW     = 32;
  localparam int LW     = 4;
  localparam int NL     = 8;
  localparam int MW     = 2;
  localparam int LINE_W = WW * LW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cpu_req = 1'b0, cpu_we = 1'b0;
  logic [AW-1:0] cpu_addr = '0;
  logic [WW-1:0] cpu_wdata = '0;
  logic cpu_stall, cpu_rvalid;
  logic [WW-1:0] cpu_rdata;
  logic bus_req, bus_cmd_vld, bus_cmd;
  logic bus_gnt = 1'b0, bus_done = 1'b0;
  logic [AW-1:0] bus_addr;
  logic [WW-1:0] bus_wdata;
  logic [LINE_W-1:0] bus_rdata = '0;
  logic snp_vld = 1'b0, snp_cmd = 1'b0;
  logic [AW-1:0] snp_addr = '0;
  logic [MW-1:0] snp_mid = '0;

  always #(CLK_P/2) clk = ~clk;

  wt_snoop_cache #(
    .ADDR_W(AW), .WORD_W(WW), .LINE_WORDS(LW), .NUM_LINES(NL), .MID_W(MW), .MASTER_ID(0)
  ) dut (
    .clk_i(clk), .rst_ni(rst_n),
    .cpu_req_i(cpu_req), .cpu_we_i(cpu_we), .cpu_addr_i(cpu_addr), .cpu_wdata_i(cpu_wdata),
    .cpu_stall_o(cpu_stall), .cpu_rvalid_o(cpu_rvalid), .cpu_rdata_o(cpu_rdata),
    .bus_req_o(bus_req), .bus_gnt_i(bus_gnt), .bus_cmd_vld_o(bus_cmd_vld), .bus_cmd_o(bus_cmd),
    .bus_addr_o(bus_addr), .bus_wdata_o(bus_wdata), .bus_done_i(bus_done), .bus_rdata_i(bus_rdata),
    .snp_vld_i(snp_vld), .snp_cmd_i(snp_cmd), .snp_addr_i(snp_addr), .snp_mid_i(snp_mid)
  );

  int n_cmp = 0, n_bad = 0;
  bit ended = 0;

  task automatic chk(bit ok, string r, longint act, longint exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  // memory and bus model
  logic [WW-1:0] mem [int];
  function automatic logic [WW-1:0] mword(int a);
    if (mem.exists(a)) return mem[a];
    return WW'(a * 40503) ^ 32'h5A5A_0000;
  endfunction

  int nrd = 0, nwr = 0;
  logic [AW-1:0] last_addr = '0;
  logic [WW-1:0] last_wdata = '0;
  int gnt_lat = 0, dat_lat = 0, arb_cnt = 0, dcnt = 0;
  bit in_data = 0;
  logic [AW-1:0] cur_addr = '0;

  bit inj_pend = 0, inj_at_gnt = 0, inj_we = 0, inj_upd = 0;
  int inj_addr = 0;
  logic [WW-1:0] inj_val = '0;
  logic [MW-1:0] inj_mid = '0;

  task automatic drive_inj();
    snp_vld  = 1'b1;
    snp_cmd  = inj_we;
    snp_addr = AW'(inj_addr);
    snp_mid  = inj_mid;
    if (inj_upd) mem[inj_addr] = inj_val;
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      bus_gnt  = 1'b0;
      bus_done = 1'b0;
      snp_vld  = 1'b0;
      if (in_data) begin
        if (dcnt == dat_lat) begin
          bus_done = 1'b1;
          for (int w = 0; w < LW; w++) bus_rdata[w*WW +: WW] = mword(int'(cur_addr) + w);
          in_data = 0;
        end else dcnt++;
      end
      if (bus_req) begin
        if (arb_cnt == gnt_lat) begin
          bus_gnt = 1'b1;
          arb_cnt = 0;
          if (inj_at_gnt) begin drive_inj(); inj_at_gnt = 0; end
        end else arb_cnt++;
      end
      if (bus_cmd_vld) begin
        cur_addr = bus_addr;
        last_addr = bus_addr;
        last_wdata = bus_wdata;
        if (bus_cmd) begin nwr++; mem[int'(bus_addr)] = bus_wdata; end
        else nrd++;
        in_data = 1;
        dcnt = 0;
        snp_vld = 1'b1; snp_cmd = bus_cmd; snp_addr = bus_addr; snp_mid = '0;
      end else if (inj_pend) begin
        drive_inj();
        inj_pend = 0;
      end
    end
  end

  // scoreboard
  logic [WW-1:0] exp_q[$];
  string tag_q[$];

  always @(negedge clk) begin
    #1;
    if (rst_n && cpu_rvalid) begin
      if (cpu_stall) chk(0, "R9 rvalid while stalled", 1, 0);
      if (exp_q.size() == 0) chk(0, "R3 unexpected rvalid", cpu_rdata, 0);
      else begin
        automatic logic [WW-1:0] e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        chk(cpu_rdata == e, t, cpu_rdata, e);
      end
    end
  end

  task automatic cpu_access(bit we, int a, logic [WW-1:0] wd, output int stalls);
    @(negedge clk);
    cpu_req = 1'b1; cpu_we = we; cpu_addr = AW'(a); cpu_wdata = wd;
    stalls = 0;
    forever begin
      #1;
      if (!cpu_stall) break;
      stalls++;
      @(negedge clk);
    end
    @(negedge clk);
    cpu_req = 1'b0;
  endtask

  task automatic cpu_read(int a, logic [WW-1:0] e, string t, output int stalls);
    exp_q.push_back(e);
    tag_q.push_back(t);
    cpu_access(0, a, '0, stalls);
  endtask

  task automatic snoop(bit we, int a, logic [WW-1:0] v, logic [MW-1:0] mid, bit upd);
    inj_we = we; inj_addr = a; inj_val = v; inj_mid = mid; inj_upd = upd;
    inj_pend = 1;
    @(negedge clk);
    #2;
  endtask

  localparam int A = 'h0120;
  localparam int B = 'h0220;
  localparam int C = 'h0134;
  localparam int D = 'h0158;
  localparam int E = 'h0310;

  initial begin
    repeat (20000) @(posedge clk);
    chk(0, "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    int st, r0, w0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    // R1: reset state
    chk(!cpu_stall && !cpu_rvalid && !bus_req && !bus_cmd_vld, "R1 idle outputs",
        {cpu_stall, cpu_rvalid, bus_req, bus_cmd_vld}, 0);

    // R2 / R8: first read misses, G=0 L=0
    r0 = nrd;
    cpu_read(A, mword(A), "R2 miss data", st);
    chk(nrd == r0 + 1, "R2 one bus read", nrd - r0, 1);
    chk(last_addr == AW'(A & ~(LW - 1)), "R2 aligned address", last_addr, A & ~(LW - 1));
    chk(st == 3, "R8 stall G0 L0", st, 3);

    // R3: hit in same line
    r0 = nrd;
    cpu_read(A + 1, mword(A + 1), "R3 hit data", st);
    chk(st == 0, "R3 no stall", st, 0);
    chk(nrd == r0, "R3 no bus read", nrd - r0, 0);

    // R4: write hit goes out and updates local copy
    w0 = nwr;
    cpu_access(1, A + 1, 32'hC0DE_0001, st);
    chk(nwr == w0 + 1, "R4 one bus write", nwr - w0, 1);
    chk(last_addr == AW'(A + 1) && last_wdata == 32'hC0DE_0001, "R4 write addr/data",
        last_wdata, 32'hC0DE_0001);
    chk(st == 3, "R9 write stall", st, 3);
    r0 = nrd;
    cpu_read(A + 1, 32'hC0DE_0001, "R4 write hit updates word", st);
    chk(nrd == r0, "R4 line stays present", nrd - r0, 0);

    // R5: write miss does not allocate
    w0 = nwr;
    cpu_access(1, C, 32'hC0DE_0002, st);
    chk(nwr == w0 + 1, "R5 write miss still on bus", nwr - w0, 1);
    r0 = nrd;
    cpu_read(C, 32'hC0DE_0002, "R5 read after write miss", st);
    chk(nrd == r0 + 1, "R5 no allocate", nrd - r0, 1);

    // R6: other master write invalidates
    snoop(1, A + 2, 32'hC0DE_0003, 2'd1, 1);
    r0 = nrd;
    cpu_read(A + 2, 32'hC0DE_0003, "R6 newer value after invalidate", st);
    chk(nrd == r0 + 1, "R6 invalidated line misses", nrd - r0, 1);

    // R7: other master read, own id write ignored
    snoop(0, A, '0, 2'd2, 0);
    snoop(1, A, 32'hDEAD_0000, 2'd0, 0);
    r0 = nrd;
    cpu_read(A, mword(A), "R7 snoop ignored", st);
    chk(nrd == r0, "R7 line still present", nrd - r0, 0);

    // R6: tag mismatch leaves line
    snoop(1, B, 32'hC0DE_0004, 2'd1, 1);
    r0 = nrd;
    cpu_read(A + 3, mword(A + 3), "R6 tag mismatch hit", st);
    chk(nrd == r0, "R6 tag mismatch no miss", nrd - r0, 0);

    // R11: conflict eviction
    r0 = nrd;
    cpu_read(B, 32'hC0DE_0004, "R11 other tag fill", st);
    cpu_read(A, mword(A), "R11 evicted line refetch", st);
    chk(nrd == r0 + 2, "R11 both miss", nrd - r0, 2);

    // R8: G=2 L=3
    gnt_lat = 2; dat_lat = 3;
    cpu_read(D, mword(D), "R8 slow bus data", st);
    chk(st == 8, "R8 stall G2 L3", st, 8);

    // R10: snoop write at grant of pending miss
    gnt_lat = 1; dat_lat = 1;
    inj_we = 1; inj_addr = E; inj_val = 32'hC0DE_0005; inj_mid = 2'd1; inj_upd = 1;
    inj_at_gnt = 1;
    r0 = nrd;
    cpu_read(E, 32'hC0DE_0005, "R10 fill with newer value", st);
    chk(inj_at_gnt == 0, "R10 snoop landed at grant", inj_at_gnt, 0);
    cpu_read(E, 32'hC0DE_0005, "R10 line present after fill", st);
    chk(nrd == r0 + 1, "R10 second read hits", nrd - r0, 1);

    repeat (3) @(negedge clk);
    chk(exp_q.size() == 0, "R9 all reads answered", exp_q.size(), 0);
    finish_run();
  end
endmodule